// File: doc/BRIEF.md
# Dual-Base Programmable Clock Prescaler

This block turns the CPU clock into a one-cycle enable strobe for a timer counter. A 3-bit exponent field `ratioSel` and a base bit `tripleBase` choose the division ratio. With the base bit clear the ratio is a power of two. With it set the ratio is three times a power of two. The counter that follows advances only in cycles where the strobe is high, so the block never creates a second clock domain.

Software may change the ratio at any time. The block detects the change and starts the count again from zero, so the first strobe after the change arrives one full new period later. Dropping `enable` holds the strobe low and clears the count. When `enable` returns, the first strobe comes one whole period later.

Top module: `dual_base_prescaler`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `tick` is 0.
- R2: With `tripleBase` = 0, `ratioSel` = n (unsigned, 0 to 7) selects a ratio of 2^n input clocks: 1, 2, 4, 8, 16, 32, 64 or 128.
- R3: With `tripleBase` = 1, `ratioSel` = n selects a ratio of 3·2^n input clocks: 3, 6, 12, 24, 48, 96, 192 or 384.
- R4: While `enable` is high and the configuration does not change, `tick` is a pulse one cycle wide. Consecutive pulses rise exactly one ratio apart.
- R5: At ratio 1, `tick` is high in every cycle that follows a rising edge at which `enable` was high and the configuration was unchanged.
- R6: After `enable` rises, the first `tick` follows the ratio-th rising edge at which `enable` is sampled high.
- R7: At a rising edge where `ratioSel` or `tripleBase` differs from the value sampled at the previous edge, the count restarts. `tick` is low after that edge, and the next pulse follows the new ratio-th edge after it. No interval between pulses is shorter than the new ratio.
- R8: At a rising edge where `enable` is low, `tick` goes low and the count returns to zero.
- R9: The internal count never exceeds the selected ratio minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the prescaler when high |
| ratioSel | input | 3 | Exponent n of the division ratio |
| tripleBase | input | 1 | 0: ratio 2^n, 1: ratio 3·2^n |
| tick | output | 1 | One-cycle enable strobe for the timer counter |

## Verification
The assertions assume that `ratioSel`, `tripleBase` and `enable` are synchronous to `clk` and settle before each rising edge. They also assume that the reset value of the configuration is ratio 1 (exponent 0, base bit 0), which is what makes the count bound hold from the first cycle. The bench changes inputs only on the falling edge. It holds each random configuration for between one cycle and several full periods, so restarts in the middle of a count and long stable runs both occur. It includes the 384 ratio, runs of ratio 1, and removal of `enable` part way through a count.

// File: rtl/prescaler_pkg.sv
package prescaler_pkg;
  localparam int SEL_W_DEF = 3;

  typedef struct packed {
    logic clear;
    logic run;
  } ps_strobe_t;
endpackage

// File: rtl/prescaler_ctrl.sv
module prescaler_ctrl
  import prescaler_pkg::*;
#(
  parameter int SEL_W = SEL_W_DEF,
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             tripleBase,
  output ps_strobe_t       strb,
  output logic [CNT_W-1:0] termVal
);
  logic [SEL_W-1:0] selQ;
  logic             baseQ;
  logic [CNT_W-1:0] termQ;
  logic [CNT_W-1:0] ratioNext;
  logic [CNT_W-1:0] termNext;
  logic             cfgChanged;

  // base multiplier is 1 or 3, then scaled by 2^n
  always_comb begin
    ratioNext = {{(CNT_W-2){1'b0}}, tripleBase, 1'b1} << ratioSel;
    termNext  = ratioNext - {{(CNT_W-1){1'b0}}, 1'b1};
  end

  assign cfgChanged = (ratioSel != selQ) || (tripleBase != baseQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      baseQ <= 1'b0;
      termQ <= '0;
    end else begin
      selQ  <= ratioSel;
      baseQ <= tripleBase;
      termQ <= termNext;
    end
  end

  always_comb begin
    strb.clear = !enable || cfgChanged;
    strb.run   = enable && !cfgChanged;
  end

  assign termVal = termQ;

  // terminal + 1 is either a power of two or three times one
  assert_ratio_shape_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($countones({1'b0, termQ} + {{CNT_W{1'b0}}, 1'b1}) inside {1, 2}));

  // R3: a triple base never yields a terminal count below 2
  assert_triple_min_R3: assert property (@(posedge clk) disable iff (!rstN)
    (baseQ |-> termQ >= 2));
endmodule

// File: rtl/prescaler_datapath.sv
module prescaler_datapath
  import prescaler_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  ps_strobe_t       strb,
  input  logic [CNT_W-1:0] termVal,
  output logic             tick
);
  logic [CNT_W-1:0] cnt;
  logic             atTerm;

  assign atTerm = (cnt == termVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (strb.clear) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (strb.run) begin
      if (atTerm) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cnt <= termVal));

  assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clear |=> (cnt == '0) && !tick));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((tick && termVal != '0) |=> !tick));

  assert_unit_every_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.run && termVal == '0) |=> tick));

  assert_tick_wraps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick |-> cnt == '0));
endmodule

// File: rtl/dual_base_prescaler.sv
module dual_base_prescaler
  import prescaler_pkg::*;
#(
  parameter int SEL_W = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [SEL_W-1:0] ratioSel,
  input  logic             tripleBase,
  output logic             tick
);
  localparam int MAX_RATIO = 3 << ((1 << SEL_W) - 1);
  localparam int CNT_W     = $clog2(MAX_RATIO + 1);

  ps_strobe_t       strb;
  logic [CNT_W-1:0] termVal;

  prescaler_ctrl #(.SEL_W(SEL_W), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioSel(ratioSel),
    .tripleBase(tripleBase), .strb(strb), .termVal(termVal)
  );

  prescaler_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .termVal(termVal), .tick(tick)
  );

  assert_disable_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enable |=> !tick));
endmodule

// File: tb/dual_base_prescaler_tb_top.sv
module dual_base_prescaler_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [2:0] ratioSel = 3'd0;
  logic       tripleBase = 1'b0;
  logic       tick;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  int    phase = 0;
  bit    expTick = 1'b0;
  int    prevSel = 0;
  bit    prevBase = 1'b0;
  bit    prevEn = 1'b0;
  bit    awaitFirst = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  dual_base_prescaler dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .ratioSel(ratioSel),
    .tripleBase(tripleBase), .tick(tick)
  );

  function automatic int ratioOf(input int n, input bit b);
    return (b ? 3 : 1) * (1 << n);
  endfunction

  function automatic string baseTag(input bit b);
    return b ? "R3" : "R2";
  endfunction

  task automatic check(input string t);
    vectors++;
    if (tick !== expTick) begin
      fails++;
      $display("FAIL %s: tick=%b expected=%b at %0t", t, tick, expTick, $time);
    end
  endtask

  // one rising edge: advance the reference, then compare at the falling edge
  task automatic step();
    @(posedge clk);
    if (!rstN) begin
      phase = 0; expTick = 1'b0; prevSel = 0; prevBase = 1'b0;
      prevEn = 1'b0; tag = "R1";
    end else if (!enable) begin
      phase = 0; expTick = 1'b0; tag = "R8";
      prevSel = int'(ratioSel); prevBase = tripleBase; prevEn = 1'b0;
    end else if (int'(ratioSel) != prevSel || tripleBase != prevBase) begin
      phase = 0; expTick = 1'b0; tag = "R7";
      prevSel = int'(ratioSel); prevBase = tripleBase;
      awaitFirst = 1'b1; prevEn = 1'b1;
    end else begin
      if (!prevEn) awaitFirst = 1'b1;
      prevEn = 1'b1;
      if (phase == ratioOf(prevSel, prevBase) - 1) begin
        phase = 0; expTick = 1'b1;
      end else begin
        phase++; expTick = 1'b0;
      end
      if (ratioOf(prevSel, prevBase) == 1) tag = "R5";
      else if (awaitFirst) tag = "R6";
      else if (expTick) tag = baseTag(prevBase);
      else tag = "R4";
      if (expTick) awaitFirst = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) step();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset holds tick low
    ratioSel = 3'd5; tripleBase = 1'b1; enable = 1'b1;
    run(4);
    @(negedge clk); rstN = 1'b1;
    step();
    // every setting of both bases, R2 and R3
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 8; n++) begin
        ratioSel = 3'(n); tripleBase = b[0]; enable = 1'b1;
        run(2 * ratioOf(n, b[0]) + 3);
      end
    end
    // R5: long ratio-1 run
    ratioSel = 3'd0; tripleBase = 1'b0; run(20);
    // R7: change part way through a count
    ratioSel = 3'd5; tripleBase = 1'b0; run(40);
    ratioSel = 3'd1; tripleBase = 1'b1; run(30);
    // R7: base bit alone changes
    tripleBase = 1'b0; run(10);
    // R8 and R6: disable part way, then resume
    ratioSel = 3'd3; run(5);
    enable = 1'b0; run(6);
    enable = 1'b1; run(20);
    // random segments
    for (int s = 0; s < 120; s++) begin
      ratioSel   = 3'($urandom_range(0, 7));
      tripleBase = 1'($urandom_range(0, 1));
      enable     = ($urandom_range(0, 9) < 8);
      run($urandom_range(1, 3 * ratioOf(int'(ratioSel), tripleBase) + 2));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule